// File: doc/BRIEF.md
# Chunk Termination and Size Logger

This block sits beside a processor that executes in atomic chunks. It decides in which cycle the open chunk has to end, and it makes the irregular endings repeatable. In record mode it counts retired instructions. It ends the chunk for four reasons: the chunk reaches its maximum size, a serializing instruction retires, the cache reports that a set is about to overflow, or a companion detector flags a retiring store that writes into code. Max-size and serializing endings come back by themselves when the run is replayed, so they are not logged. The two hazard-driven endings are not deterministic, so each one produces a log entry that carries a cause code and an instruction distance.

In replay mode the block pulls entries from a log read port. It ends a chunk when the retired-instruction distance reaches the logged value, and it ignores live hazard strobes. The logged distance counts instructions since the previous logged boundary. Unlogged commits that fall in between therefore replay naturally without moving the logged cut. When the previous commit was logged, the distance equals the chunk size.

The state machine has five states:
- `ST_IDLE`: the reset state. It lasts one cycle and picks the mode.
- `ST_REC`: record counting.
- `ST_LOGW`: a log entry is offered and the commit waits for it.
- `ST_RPLD`: replay, waiting for and popping the next entry.
- `ST_RPRUN`: replay, counting toward the loaded target.

Its transitions are:
- IDLE→REC when the mode input is low, and IDLE→RPLD when it is high.
- REC→LOGW on a hazard ending.
- LOGW→REC when the log accepts the entry.
- RPLD→RPRUN on a pop that does not hit in the same cycle.
- RPRUN→RPLD, or RPLD→RPLD, on a target hit.

Top module: `chunk_cut_logger`

## Requirements
- R1: After reset, commit_req, log_wr_vld and log_rd_pop are all low.
- R2: When a retirement brings the open chunk to MAX_CHUNK instructions, commit_req is high in the following cycle and no log entry is written. This holds in both modes.
- R3: In record mode, an overflow request in a cycle where the chunk (including that cycle's retirement) is non-empty ends the chunk and offers a log entry with cause 2'b01. The same request with an empty chunk is ignored.
- R4: In record mode, a self-modification hit together with retire_vld ends the chunk with that store included, and the entry has cause 2'b10. The hit takes priority over an overflow request in the same cycle.
- R5: A serializing instruction with a non-empty chunk ends the chunk in both modes. commit_req rises the next cycle and nothing is logged.
- R6: log_wr_vld stays high with stable cause and count until log_wr_rdy is high. commit_req for that chunk is high in the cycle after the accepting cycle.
- R7: Retirements during a log wait are counted into the next chunk.
- R8: log_wr_count is the number of instructions retired since the previous logged boundary, or since reset, and it is never zero.
- R9: In replay mode, log_rd_pop is high exactly when in ST_RPLD with log_rd_vld high. A chunk ends when the distance since the previous logged boundary (including the current retirement) equals the loaded count. The next entry is then popped.
- R10: In replay mode, overflow requests and self-modification hits have no effect, and log_wr_vld stays low.
- R11: In replay mode, max-size and serializing endings do not reset the distance toward the logged target.
- R12: commit_req is high for exactly one cycle per chunk ending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| replay_mode | input | 1 | 0 = record, 1 = replay; held stable outside reset |
| retire_vld | input | 1 | One instruction retires this cycle |
| ovf_req | input | 1 | Cache set about to overflow |
| serialize_req | input | 1 | Serializing instruction retiring |
| smc_hit | input | 1 | Retiring store writes into code (valid with retire_vld) |
| commit_req | output | 1 | One-cycle request to commit the open chunk |
| log_wr_vld | output | 1 | Log entry offered |
| log_wr_rdy | input | 1 | Log accepts the entry |
| log_wr_cause | output | 2 | 01 overflow, 10 self-modification |
| log_wr_count | output | CNT_W | Instruction distance of the entry |
| log_rd_vld | input | 1 | Replay entry available |
| log_rd_count | input | CNT_W | Replay entry distance |
| log_rd_pop | output | 1 | Replay entry consumed |

## Verification
The bench builds the block with MAX_CHUNK = 12 and CNT_W = 16. The small maximum makes max-size commits frequent, so they interleave with hazard endings, log stalls and serializing endings within a few hundred cycles. In replay, targets up to 31 regularly span one or two max-size commits, which brings the distance-preservation rule of R11 within reach. Random log back-pressure of up to several cycles exercises R6 and R7 without letting a waiting chunk approach the maximum.

// File: rtl/ccl_pkg.sv
`timescale 1ns/1ps
package ccl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REC,
        ST_LOGW,
        ST_RPLD,
        ST_RPRUN
    } ccl_state_e;

    localparam logic [1:0] CAUSE_OVF = 2'b01;
    localparam logic [1:0] CAUSE_SMC = 2'b10;
endpackage

// File: rtl/ccl_tally.sv
`timescale 1ns/1ps
module ccl_tally #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] q,
    output logic [W-1:0] sum
);
    assign sum = q + W'(inc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else          q <= sum;
    end
endmodule

// File: rtl/ccl_hold.sv
`timescale 1ns/1ps
module ccl_hold #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/chunk_cut_logger.sv
`timescale 1ns/1ps
module chunk_cut_logger
    import ccl_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int MAX_CHUNK = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             replay_mode,
    input  logic             retire_vld,
    input  logic             ovf_req,
    input  logic             serialize_req,
    input  logic             smc_hit,
    output logic             commit_req,
    output logic             log_wr_vld,
    input  logic             log_wr_rdy,
    output logic [1:0]       log_wr_cause,
    output logic [CNT_W-1:0] log_wr_count,
    input  logic             log_rd_vld,
    input  logic [CNT_W-1:0] log_rd_count,
    output logic             log_rd_pop
);
    localparam int               CHUNK_W = $clog2(MAX_CHUNK + 1);
    localparam int               ENT_W   = CNT_W + 2;
    localparam logic [CHUNK_W-1:0] MAX_V = CHUNK_W'(MAX_CHUNK);

    ccl_state_e state, nxt_state;

    logic [CHUNK_W-1:0] chunk_q, chunk_sum;
    logic [CNT_W-1:0]   span_q, span_sum;
    logic [CNT_W-1:0]   tgt_q, tgt_eff;
    logic [ENT_W-1:0]   ent_q, ent_d;
    logic               chunk_clr, span_clr, ent_ld, tgt_ld;
    logic               commit_d, commit_q;
    logic               smc_end, hz_end, plain_end, tgt_live, tgt_hit;
    logic [1:0]         cause_d;

    // instruction count of the open chunk
    ccl_tally #(.W(CHUNK_W)) u_chunk (
        .clk(clk), .rst_n(rst_n), .inc(retire_vld), .clr(chunk_clr),
        .q(chunk_q), .sum(chunk_sum)
    );

    // distance since the last logged boundary
    ccl_tally #(.W(CNT_W)) u_span (
        .clk(clk), .rst_n(rst_n), .inc(retire_vld), .clr(span_clr),
        .q(span_q), .sum(span_sum)
    );

    ccl_hold #(.W(ENT_W)) u_entry (
        .clk(clk), .rst_n(rst_n), .load(ent_ld), .d(ent_d), .q(ent_q)
    );

    ccl_hold #(.W(CNT_W)) u_target (
        .clk(clk), .rst_n(rst_n), .load(tgt_ld), .d(log_rd_count), .q(tgt_q)
    );

    // trigger decode
    always_comb begin
        smc_end   = retire_vld && smc_hit;
        hz_end    = (smc_end || ovf_req) && (chunk_sum != '0);
        plain_end = (serialize_req && (chunk_sum != '0)) || (chunk_sum == MAX_V);
        cause_d   = smc_end ? CAUSE_SMC : CAUSE_OVF;
        ent_d     = {cause_d, span_sum};
        tgt_live  = (state == ST_RPRUN) || ((state == ST_RPLD) && log_rd_vld);
        tgt_eff   = (state == ST_RPLD) ? log_rd_count : tgt_q;
        tgt_hit   = tgt_live && (span_sum == tgt_eff);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // next state and datapath controls
    always_comb begin
        nxt_state = state;
        chunk_clr = 1'b0;
        span_clr  = 1'b0;
        commit_d  = 1'b0;
        ent_ld    = 1'b0;
        tgt_ld    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                nxt_state = replay_mode ? ST_RPLD : ST_REC;
            end
            ST_REC: begin
                if (hz_end) begin
                    ent_ld    = 1'b1;
                    chunk_clr = 1'b1;
                    span_clr  = 1'b1;
                    nxt_state = ST_LOGW;
                end else if (plain_end) begin
                    commit_d  = 1'b1;
                    chunk_clr = 1'b1;
                end
            end
            ST_LOGW: begin
                if (log_wr_rdy) begin
                    commit_d  = 1'b1;
                    nxt_state = ST_REC;
                end
            end
            ST_RPLD, ST_RPRUN: begin
                if (tgt_hit) begin
                    commit_d  = 1'b1;
                    chunk_clr = 1'b1;
                    span_clr  = 1'b1;
                    nxt_state = ST_RPLD;
                end else begin
                    if (plain_end) begin
                        commit_d  = 1'b1;
                        chunk_clr = 1'b1;
                    end
                    if ((state == ST_RPLD) && log_rd_vld) begin
                        tgt_ld    = 1'b1;
                        nxt_state = ST_RPRUN;
                    end
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) commit_q <= 1'b0;
        else        commit_q <= commit_d;
    end

    // outputs
    always_comb begin
        commit_req   = commit_q;
        log_wr_vld   = (state == ST_LOGW);
        log_wr_cause = ent_q[ENT_W-1 -: 2];
        log_wr_count = ent_q[CNT_W-1:0];
        log_rd_pop   = (state == ST_RPLD) && log_rd_vld;
    end
endmodule

// File: rtl/ccl_checker.sv
`timescale 1ns/1ps
module ccl_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             replay_mode,
    input logic             commit_req,
    input logic             log_wr_vld,
    input logic             log_wr_rdy,
    input logic [1:0]       log_wr_cause,
    input logic [CNT_W-1:0] log_wr_count,
    input logic             log_rd_vld,
    input logic             log_rd_pop
);
    assert_entry_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (log_wr_vld && !log_wr_rdy) |=> (log_wr_vld && $stable(log_wr_count) && $stable(log_wr_cause)));

    assert_commit_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (log_wr_vld && log_wr_rdy) |=> commit_req);

    assert_cause_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        log_wr_vld |-> ($countones(log_wr_cause) == 1));

    assert_count_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        log_wr_vld |-> (log_wr_count != '0));

    assert_replay_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        replay_mode |-> !log_wr_vld);

    assert_pop_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        log_rd_pop |-> (log_rd_vld && replay_mode));
endmodule

bind chunk_cut_logger ccl_checker #(.CNT_W(CNT_W)) u_ccl_checker (
    .clk(clk), .rst_n(rst_n), .replay_mode(replay_mode), .commit_req(commit_req),
    .log_wr_vld(log_wr_vld), .log_wr_rdy(log_wr_rdy), .log_wr_cause(log_wr_cause),
    .log_wr_count(log_wr_count), .log_rd_vld(log_rd_vld), .log_rd_pop(log_rd_pop)
);

// File: tb/tb_chunk_cut_logger.sv
`timescale 1ns/1ps
module tb_chunk_cut_logger;
    localparam int CNT_W = 16;
    localparam int MAXC  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic replay_mode = 1'b0;
    logic retire_vld = 1'b0, ovf_req = 1'b0, serialize_req = 1'b0, smc_hit = 1'b0;
    logic log_wr_rdy = 1'b0, log_rd_vld = 1'b0;
    logic [CNT_W-1:0] log_rd_count = '0;
    logic commit_req, log_wr_vld, log_rd_pop;
    logic [1:0] log_wr_cause;
    logic [CNT_W-1:0] log_wr_count;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    chunk_cut_logger #(.CNT_W(CNT_W), .MAX_CHUNK(MAXC)) dut (
        .clk(clk), .rst_n(rst_n), .replay_mode(replay_mode), .retire_vld(retire_vld),
        .ovf_req(ovf_req), .serialize_req(serialize_req), .smc_hit(smc_hit),
        .commit_req(commit_req), .log_wr_vld(log_wr_vld), .log_wr_rdy(log_wr_rdy),
        .log_wr_cause(log_wr_cause), .log_wr_count(log_wr_count),
        .log_rd_vld(log_rd_vld), .log_rd_count(log_rd_count), .log_rd_pop(log_rd_pop)
    );

    // reference model state, built from the requirements
    // 0 idle, 1 record, 2 log wait, 3 replay load, 4 replay run
    int m_st, m_cnt, m_span, m_tgt, m_cause, m_ecnt;
    bit m_com;

    function automatic void model_reset();
        m_st = 0; m_cnt = 0; m_span = 0; m_tgt = 0; m_cause = 0; m_ecnt = 0; m_com = 0;
    endfunction

    function automatic void model_step(bit ret, bit ovf, bit ser, bit smc, bit rdy,
                                       bit rvld, int rcnt, bit mode);
        int n, s, te;
        bit tv, ncom;
        n = m_cnt + int'(ret);
        s = m_span + int'(ret);
        ncom = 0;
        case (m_st)
            0: begin m_cnt = n; m_span = s; m_st = mode ? 3 : 1; end
            1: begin
                if (n != 0 && ((smc && ret) || ovf)) begin
                    m_ecnt = s; m_cause = (smc && ret) ? 2 : 1;
                    m_cnt = 0; m_span = 0; m_st = 2;
                end else if ((ser && n != 0) || n == MAXC) begin
                    ncom = 1; m_cnt = 0; m_span = s;
                end else begin
                    m_cnt = n; m_span = s;
                end
            end
            2: begin
                m_cnt = n; m_span = s;
                if (rdy) begin ncom = 1; m_st = 1; end
            end
            default: begin
                tv = (m_st == 4) || rvld;
                te = (m_st == 3) ? rcnt : m_tgt;
                if (tv && s == te) begin
                    ncom = 1; m_cnt = 0; m_span = 0; m_st = 3;
                end else begin
                    if ((ser && n != 0) || n == MAXC) begin ncom = 1; m_cnt = 0; end
                    else m_cnt = n;
                    m_span = s;
                    if (m_st == 3 && rvld) begin m_tgt = rcnt; m_st = 4; end
                end
            end
        endcase
        m_com = ncom;
    endfunction

    task automatic chk(int act, int exp, string tag, string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(bit ret, bit ovf, bit ser, bit smc, bit rdy, bit rvld,
                        int rcnt, string tag);
        @(negedge clk);
        retire_vld = ret; ovf_req = ovf; serialize_req = ser; smc_hit = smc;
        log_wr_rdy = rdy; log_rd_vld = rvld; log_rd_count = CNT_W'(rcnt);
        #1;
        chk(int'(commit_req), int'(m_com), tag, "commit_req");
        chk(int'(log_wr_vld), (m_st == 2) ? 1 : 0, tag, "log_wr_vld");
        if (m_st == 2) begin
            chk(int'(log_wr_cause), m_cause, tag, "log_wr_cause");
            chk(int'(log_wr_count), m_ecnt, tag, "log_wr_count");
        end
        chk(int'(log_rd_pop), (m_st == 3 && rvld) ? 1 : 0, tag, "log_rd_pop");
        @(posedge clk);
        model_step(ret, ovf, ser, smc, rdy, rvld, rcnt, replay_mode);
    endtask

    task automatic do_reset(bit mode);
        @(negedge clk);
        rst_n = 1'b0; replay_mode = mode;
        retire_vld = 0; ovf_req = 0; serialize_req = 0; smc_hit = 0;
        log_wr_rdy = 0; log_rd_vld = 0;
        model_reset();
        repeat (3) @(negedge clk);
        chk(int'(commit_req), 0, "R1", "reset commit_req");
        chk(int'(log_wr_vld), 0, "R1", "reset log_wr_vld");
        chk(int'(log_rd_pop), 0, "R1", "reset log_rd_pop");
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int wait_left;
        void'($urandom(32'd4242));

        // ---------------- record, directed ----------------
        do_reset(1'b0);
        step(0,0,0,0,1,0,0,"R1");
        for (int i = 0; i < MAXC; i++) step(1,0,0,0,1,0,0,"R2");
        step(0,0,0,0,1,0,0,"R2");       // max-size commit visible, nothing logged
        step(0,0,0,0,1,0,0,"R12");      // single-cycle pulse
        step(0,1,0,0,1,0,0,"R3");       // overflow with empty chunk ignored
        step(0,0,0,0,1,0,0,"R3");
        for (int i = 0; i < 3; i++) step(1,0,0,0,0,0,0,"R8");
        step(0,1,0,0,0,0,0,"R3");       // overflow ends chunk of 3
        step(1,0,0,0,0,0,0,"R7");       // waiting, retire into next chunk
        step(1,0,0,0,0,0,0,"R6");
        step(0,0,0,0,1,0,0,"R6");       // accepted
        step(0,0,0,0,1,0,0,"R6");       // commit visible
        step(1,0,0,0,1,0,0,"R7");
        step(1,1,0,1,1,0,0,"R4");       // smc beats overflow, store included
        step(0,0,0,0,1,0,0,"R4");
        step(0,0,0,0,1,0,0,"R4");
        step(1,0,0,0,1,0,0,"R5");
        step(1,0,1,0,1,0,0,"R5");       // serialize, unlogged
        step(0,0,0,0,1,0,0,"R5");
        step(1,0,0,0,1,0,0,"R8");
        step(1,1,0,0,1,0,0,"R8");       // distance spans serialized chunk
        step(0,0,0,0,1,0,0,"R8");
        step(0,0,0,0,1,0,0,"R12");

        // ---------------- record, random ----------------
        wait_left = 0;
        for (int i = 0; i < 800; i++) begin
            bit rdy;
            if (m_st == 2) begin
                rdy = (wait_left == 0);
                if (wait_left > 0) wait_left--;
            end else begin
                rdy = 1'b1;
                wait_left = $urandom % 4;
            end
            step(($urandom % 4) != 0, ($urandom % 17) == 0, ($urandom % 29) == 0,
                 ($urandom % 23) == 0, rdy, 0, 0, "R3");
        end
        for (int i = 0; i < 6; i++) step(0,0,0,0,1,0,0,"R6");

        // ---------------- replay, directed ----------------
        do_reset(1'b1);
        step(0,0,0,0,0,0,0,"R1");
        step(0,0,0,0,0,0,5,"R9");       // no entry yet
        step(1,0,0,0,0,1,5,"R9");       // pop target 5
        for (int i = 0; i < 4; i++) step(1,1,0,1,1,0,0,"R10");  // live hazards ignored
        step(0,0,0,0,0,0,0,"R9");       // commit at 5
        step(1,0,0,0,0,1,20,"R11");     // pop target 20
        for (int i = 0; i < 12; i++) step(1,0,0,0,0,0,0,"R11"); // max-size at 12
        step(1,0,1,0,0,0,0,"R11");      // serialize, distance kept
        for (int i = 0; i < 6; i++) step(1,0,0,0,0,0,0,"R11"); // hits 20
        step(0,0,0,0,0,0,0,"R12");
        step(0,0,0,0,0,0,0,"R12");

        // ---------------- replay, random ----------------
        for (int i = 0; i < 800; i++) begin
            step(($urandom % 4) != 0, ($urandom % 5) == 0, ($urandom % 37) == 0,
                 ($urandom % 5) == 0, $urandom % 2, 1, 2 + int'($urandom % 30), "R9");
        end

        summary();
        $finish;
    end
endmodule